// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of address translations. It sits beside a load/store unit. Each lookup presents a virtual address, the current address-space tag, and whether the access is a write and whether it comes from user mode. One cycle after the lookup is accepted, the block answers with a registered response. The response gives hit or miss, the physical address, a permission fault flag, and the entry's modified and referenced state. A miss is only reported. Whatever services it (a table walker or a software handler) writes the new translation through the fill port.

Every slot carries a tag for its address space. Translations of other processes can therefore stay resident across a context switch. A flush-all command clears the whole table. A flush-by-tag command clears only one address space. Replacement uses hardware least-recently-used order, and empty slots are always used before any eviction.

The lookup request and the lookup response are valid/ready streams. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low in three cases: while a flush is asserted, while `fill_valid` is high, or while a response is waiting that `resp_ready` has not taken. A response, once valid, holds every field stable until `resp_ready` is seen high. The fill port is also valid/ready. `fill_ready` is low only while a flush is asserted. The flush pins are plain control inputs that act on the edge where they are high.

Top module: `tlb_asid_cache`

## Requirements
- R1: A lookup hits when some valid slot has the request's virtual page number and the request's address-space tag. Its response comes on the clock edge after acceptance, with `resp_hit`=1 and `resp_paddr` = {slot frame number, unchanged 12-bit page offset}.
- R2: A lookup with no such slot responds with `resp_hit`=0, `resp_fault`=0 and `resp_paddr`=0. A slot holding the same page under another tag stays resident and still hits under its own tag.
- R3: Protection bit 0 means writable and bit 1 means user-accessible. A hit faults in two cases: a write to a slot with bit 0 clear, or a user access to a slot with bit 1 clear. A faulting hit reports `resp_hit`=1 and `resp_fault`=1, and it does not set the modified bit.
- R4: A permitted write hit sets the slot's modified bit. `resp_modified` reports the bit after the access, and a read leaves the bit unchanged.
- R5: A fill clears the slot's referenced bit, and any hit sets it. `resp_ref_prev` reports the value the bit had before this lookup.
- R6: `flush_all` high on an edge invalidates every slot, so all later lookups miss.
- R7: `flush_asid_en` high on an edge invalidates exactly the slots whose tag equals `flush_asid`. Other slots keep hitting.
- R8: A fill of a new translation goes to the lowest-numbered invalid slot whenever one exists, evicting nothing.
- R9: With every slot valid, a fill of a new translation replaces the least recently used slot. Both hits and fills make a slot most recently used.
- R10: A fill whose page and tag already match a valid slot overwrites that slot. No other slot is evicted, and later hits return the new frame.
- R11: Flush takes priority over fill, and fill takes priority over lookup. A response not taken holds stable, and `req_ready` stays low until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request may be taken |
| req_vaddr | input | 32 | Virtual address (page number above a 12-bit offset) |
| req_asid | input | 8 | Current address-space tag |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Consumer takes the response |
| resp_hit | output | 1 | Translation found |
| resp_fault | output | 1 | Protection fault on a hit |
| resp_paddr | output | 32 | Physical address |
| resp_modified | output | 1 | Slot modified bit after the access |
| resp_ref_prev | output | 1 | Slot referenced bit before the access |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill may be taken |
| fill_vpn | input | 20 | Page number to install |
| fill_asid | input | 8 | Address-space tag to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_prot | input | 2 | Protection: bit 1 user, bit 0 writable |
| flush_all | input | 1 | Invalidate every slot |
| flush_asid_en | input | 1 | Invalidate the slots of one tag |
| flush_asid | input | 8 | Tag to invalidate |

## Verification
A lookup's response is due one edge after acceptance. The bench drives each request just after a falling edge and reads the response at the next falling edge, after the single output register has loaded. Fills and flushes change the table on the edge where they are taken, so a lookup driven in the next cycle already sees the change. The back-pressure test holds `resp_ready` low for two extra cycles. Across those cycles it checks that the response stays frozen and that `req_ready` stays low.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PROT_W = 2;

  typedef struct packed {
    logic user;
    logic write;
  } prot_t;

  function automatic logic access_ok(input prot_t p, input logic is_wr, input logic is_usr);
    return (!is_wr || p.write) && (!is_usr || p.user);
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IW    = $clog2(N)
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0][VPN_W-1:0]  vpn_tab,
  input  logic [N-1:0][ASID_W-1:0] asid_tab,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [ASID_W-1:0]        key_asid,
  output logic [N-1:0]             hit_vec,
  output logic                     hit,
  output logic [IW-1:0]            hit_idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (vpn_tab[g] == key_vpn) && (asid_tab[g] == key_asid);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IW'(i);
    end
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N   = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  input  logic [N-1:0]  valid,
  output logic [IW-1:0] victim_idx
);
  localparam logic [IW-1:0] OLDEST = IW'(N - 1);

  logic [N-1:0][IW-1:0] age_q;
  logic [IW-1:0]        touch_age;

  assign touch_age = age_q[touch_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)        age_q[i] <= '0;
        else if (age_q[i] < touch_age)  age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    victim_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (!valid[i] && !found) begin
        victim_idx = IW'(i);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++) begin
        if (age_q[i] == OLDEST) victim_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_asid_cache.sv
module tlb_asid_cache
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_write,
  input  logic              req_user,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_hit,
  output logic              resp_fault,
  output logic [PA_W-1:0]   resp_paddr,
  output logic              resp_modified,
  output logic              resp_ref_prev,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PROT_W-1:0] fill_prot,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid
);
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  prot_t [ENTRIES-1:0]            prot_q;
  logic [ENTRIES-1:0]             mod_q;
  logic [ENTRIES-1:0]             ref_q;

  logic flush_any, fill_go, req_go;
  assign flush_any  = flush_all | flush_asid_en;
  assign fill_ready = !flush_any;
  assign req_ready  = !flush_any && !fill_valid && (!resp_valid || resp_ready);
  assign fill_go    = fill_valid && fill_ready;
  assign req_go     = req_valid && req_ready;

  logic [VPN_W-1:0] req_vpn;
  logic [OFF_W-1:0] req_off;
  assign req_vpn = req_vaddr[VA_W-1:OFF_W];
  assign req_off = req_vaddr[OFF_W-1:0];

  logic [ENTRIES-1:0] look_vec, fill_vec;
  logic               look_hit, fill_hit;
  logic [IW-1:0]      look_idx, fill_match_idx, victim_idx, fill_idx;

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_look_match (
    .valid(valid_q), .vpn_tab(vpn_q), .asid_tab(asid_q),
    .key_vpn(req_vpn), .key_asid(req_asid),
    .hit_vec(look_vec), .hit(look_hit), .hit_idx(look_idx)
  );

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_match (
    .valid(valid_q), .vpn_tab(vpn_q), .asid_tab(asid_q),
    .key_vpn(fill_vpn), .key_asid(fill_asid),
    .hit_vec(fill_vec), .hit(fill_hit), .hit_idx(fill_match_idx)
  );

  assign fill_idx = fill_hit ? fill_match_idx : victim_idx;

  logic          touch_en;
  logic [IW-1:0] touch_idx;
  assign touch_en  = fill_go || (req_go && look_hit);
  assign touch_idx = fill_go ? fill_idx : look_idx;

  tlb_lru #(.N(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch_en(touch_en), .touch_idx(touch_idx),
    .valid(valid_q), .victim_idx(victim_idx)
  );

  logic look_ok, look_mod_set;
  assign look_ok      = access_ok(prot_q[look_idx], req_write, req_user);
  assign look_mod_set = look_hit && look_ok && req_write;

  logic [ENTRIES-1:0] flush_mask;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_flush
    assign flush_mask[g] = flush_all || (flush_asid_en && (asid_q[g] == flush_asid));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      vpn_q   <= '0;
      asid_q  <= '0;
      pfn_q   <= '0;
      prot_q  <= '0;
      mod_q   <= '0;
      ref_q   <= '0;
    end else if (flush_any) begin
      valid_q <= valid_q & ~flush_mask;
    end else if (fill_go) begin
      valid_q[fill_idx] <= 1'b1;
      vpn_q[fill_idx]   <= fill_vpn;
      asid_q[fill_idx]  <= fill_asid;
      pfn_q[fill_idx]   <= fill_pfn;
      prot_q[fill_idx]  <= prot_t'(fill_prot);
      mod_q[fill_idx]   <= 1'b0;
      ref_q[fill_idx]   <= 1'b0;
    end else if (req_go && look_hit) begin
      ref_q[look_idx] <= 1'b1;
      if (look_mod_set) mod_q[look_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid    <= 1'b0;
      resp_hit      <= 1'b0;
      resp_fault    <= 1'b0;
      resp_paddr    <= '0;
      resp_modified <= 1'b0;
      resp_ref_prev <= 1'b0;
    end else if (req_go) begin
      resp_valid    <= 1'b1;
      resp_hit      <= look_hit;
      resp_fault    <= look_hit && !look_ok;
      resp_paddr    <= look_hit ? {pfn_q[look_idx], req_off} : '0;
      resp_modified <= look_hit && (mod_q[look_idx] || look_mod_set);
      resp_ref_prev <= look_hit && ref_q[look_idx];
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tlb_asid_cache_chk.sv
module tlb_asid_cache_chk #(
  parameter int ENTRIES = 16,
  parameter int PA_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               resp_valid,
  input logic               resp_ready,
  input logic               resp_hit,
  input logic               resp_fault,
  input logic [PA_W-1:0]    resp_paddr,
  input logic               fill_ready,
  input logic               flush_all,
  input logic               flush_asid_en,
  input logic [ENTRIES-1:0] entry_valid,
  input logic [ENTRIES-1:0] look_vec
);
  // R11: an untaken response holds
  p_resp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_hit) && $stable(resp_paddr) && $stable(resp_fault));

  // R11: flush blocks both fill and lookup
  p_flush_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all || flush_asid_en) |-> !fill_ready && !req_ready);

  // R6: flush-all empties the table
  p_flush_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> entry_valid == '0);

  // R3: faults only on hits
  p_fault_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> resp_hit);

  // R2: miss carries zero address
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_hit |-> resp_paddr == '0);

  // R10: never two slots for one page and tag
  p_unique_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0(look_vec));
endmodule

bind tlb_asid_cache tlb_asid_cache_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_hit(resp_hit),
  .resp_fault(resp_fault), .resp_paddr(resp_paddr), .fill_ready(fill_ready),
  .flush_all(flush_all), .flush_asid_en(flush_asid_en),
  .entry_valid(valid_q), .look_vec(look_vec)
);

// File: tb/tb_tlb_asid_cache.sv
module tb_tlb_asid_cache;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0, req_user = 0;
  logic        req_ready;
  logic [31:0] req_vaddr = 0;
  logic [7:0]  req_asid = 0;
  logic        resp_valid, resp_hit, resp_fault, resp_modified, resp_ref_prev;
  logic        resp_ready = 1;
  logic [31:0] resp_paddr;
  logic        fill_valid = 0, fill_ready;
  logic [19:0] fill_vpn = 0, fill_pfn = 0;
  logic [7:0]  fill_asid = 0, flush_asid = 0;
  logic [1:0]  fill_prot = 0;
  logic        flush_all = 0, flush_asid_en = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_asid_cache dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_asid(req_asid), .req_write(req_write), .req_user(req_user),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_hit(resp_hit),
    .resp_fault(resp_fault), .resp_paddr(resp_paddr), .resp_modified(resp_modified),
    .resp_ref_prev(resp_ref_prev), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn), .fill_prot(fill_prot),
    .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic look(input logic [7:0] asid, input logic [19:0] vpn, input logic [11:0] off,
                      input logic wr, input logic usr);
    @(negedge clk);
    req_valid = 1; req_asid = asid; req_vaddr = {vpn, off}; req_write = wr; req_user = usr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic fill(input logic [7:0] asid, input logic [19:0] vpn, input logic [19:0] pfn,
                      input logic [1:0] prot);
    @(negedge clk);
    fill_valid = 1; fill_asid = asid; fill_vpn = vpn; fill_pfn = pfn; fill_prot = prot;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_flush(input bit all, input logic [7:0] asid);
    @(negedge clk);
    flush_all = all; flush_asid_en = !all; flush_asid = asid;
    @(negedge clk);
    flush_all = 0; flush_asid_en = 0;
  endtask

  task automatic expect_hit(input string tag, input logic [7:0] asid, input logic [19:0] vpn,
                            input logic [19:0] pfn);
    look(asid, vpn, 12'h3a5, 0, 0);
    chk(resp_valid && resp_hit && resp_paddr == {pfn, 12'h3a5}, tag,
        {31'd0, resp_hit, resp_paddr}, {31'd0, 1'b1, pfn, 12'h3a5});
  endtask

  task automatic expect_miss(input string tag, input logic [7:0] asid, input logic [19:0] vpn);
    look(asid, vpn, 12'h011, 0, 0);
    chk(resp_valid && !resp_hit && !resp_fault && resp_paddr == 0, tag,
        {resp_hit, resp_fault, resp_paddr}, 64'd0);
  endtask

  function automatic logic [7:0] asid_of(input int i);
    return (i == 5) ? 8'd2 : 8'd1;
  endfunction

  task automatic t_reset;
    chk(!resp_valid && req_ready && fill_ready, "R11 reset state",
        {resp_valid, req_ready, fill_ready}, 3'b011);
    expect_miss("R2 empty table miss", 8'd1, 20'h00010);
  endtask

  task automatic t_basic_and_asid;
    fill(8'd3, 20'h12345, 20'habcde, 2'b11);
    expect_hit("R1 basic hit", 8'd3, 20'h12345, 20'habcde);
    expect_miss("R2 other tag misses", 8'd4, 20'h12345);
    fill(8'd4, 20'h12345, 20'h00777, 2'b11);
    expect_hit("R2 tag 4 entry hits", 8'd4, 20'h12345, 20'h00777);
    expect_hit("R2 tag 3 entry stays resident", 8'd3, 20'h12345, 20'habcde);
  endtask

  task automatic t_perm_and_bits;
    fill(8'd3, 20'h00aaa, 20'h00bbb, 2'b10);
    look(8'd3, 20'h00aaa, 12'h004, 1, 0);
    chk(resp_hit && resp_fault, "R3 write to read-only faults", {resp_hit, resp_fault}, 2'b11);
    look(8'd3, 20'h00aaa, 12'h004, 0, 0);
    chk(!resp_fault && !resp_modified, "R3 faulting write left modified clear",
        {resp_fault, resp_modified}, 2'b00);
    fill(8'd3, 20'h00ccc, 20'h00ddd, 2'b01);
    look(8'd3, 20'h00ccc, 12'h000, 0, 1);
    chk(resp_hit && resp_fault, "R3 user access to supervisor page faults",
        {resp_hit, resp_fault}, 2'b11);
    fill(8'd3, 20'h00eee, 20'h00fff, 2'b11);
    look(8'd3, 20'h00eee, 12'h000, 0, 1);
    chk(!resp_fault && !resp_modified && !resp_ref_prev, "R5 fresh read: ref_prev 0, modified 0",
        {resp_fault, resp_modified, resp_ref_prev}, 3'b000);
    look(8'd3, 20'h00eee, 12'h000, 1, 1);
    chk(!resp_fault && resp_modified && resp_ref_prev, "R4 write sets modified, R5 ref_prev 1",
        {resp_fault, resp_modified, resp_ref_prev}, 3'b011);
    look(8'd3, 20'h00eee, 12'h000, 0, 0);
    chk(resp_modified, "R4 modified persists on read", resp_modified, 1);
    fill(8'd3, 20'h00eee, 20'h00fff, 2'b11);
    look(8'd3, 20'h00eee, 12'h000, 0, 0);
    chk(!resp_modified && !resp_ref_prev, "R5 refill clears referenced and modified",
        {resp_modified, resp_ref_prev}, 2'b00);
  endtask

  task automatic t_backpressure;
    fill(8'd9, 20'h00055, 20'h00066, 2'b11);
    @(negedge clk);
    resp_ready = 0;
    look(8'd9, 20'h00055, 12'h123, 0, 0);
    chk(resp_valid && !req_ready && resp_paddr == 32'h00066123, "R11 held response, ready low",
        {resp_valid, req_ready, resp_paddr}, {2'b10, 32'h00066123});
    @(negedge clk);
    @(negedge clk);
    chk(resp_valid && resp_hit && resp_paddr == 32'h00066123 && !req_ready, "R11 response stable",
        {resp_valid, resp_hit, resp_paddr}, {2'b11, 32'h00066123});
    resp_ready = 1;
    @(negedge clk);
    chk(!resp_valid && req_ready, "R11 response released", {resp_valid, req_ready}, 2'b01);
    @(negedge clk);
    fill_valid = 1; fill_asid = 8'd9; fill_vpn = 20'h00056; fill_pfn = 20'h00067; fill_prot = 2'b11;
    req_valid = 1;
    #1;
    chk(!req_ready && fill_ready, "R11 fill outranks lookup", {req_ready, fill_ready}, 2'b01);
    flush_all = 1;
    #1;
    chk(!req_ready && !fill_ready, "R11 flush outranks fill", {req_ready, fill_ready}, 2'b00);
    flush_all = 0; fill_valid = 0; req_valid = 0;
  endtask

  task automatic t_replacement;
    do_flush(1, 8'd0);
    expect_miss("R6 flush-all clears", 8'd3, 20'h12345);
    for (int i = 0; i < N; i++) fill(asid_of(i), 20'h00100 + 20'(i), 20'h00200 + 20'(i), 2'b11);
    for (int i = 0; i < N; i++)
      expect_hit("R8 each fill took its own empty slot", asid_of(i), 20'h00100 + 20'(i), 20'h00200 + 20'(i));
    expect_hit("R9 promote first entry", 8'd1, 20'h00100, 20'h00200);
    fill(8'd1, 20'h001aa, 20'h002aa, 2'b11);
    expect_miss("R9 least recent evicted", 8'd1, 20'h00101);
    expect_hit("R9 promoted entry kept", 8'd1, 20'h00100, 20'h00200);
    expect_hit("R9 new entry present", 8'd1, 20'h001aa, 20'h002aa);
    do_flush(0, 8'd2);
    expect_miss("R7 tag 2 entry flushed", 8'd2, 20'h00105);
    expect_hit("R7 tag 1 entry kept", 8'd1, 20'h00104, 20'h00204);
    fill(8'd1, 20'h001bb, 20'h002bb, 2'b11);
    expect_hit("R8 fill into freed slot", 8'd1, 20'h001bb, 20'h002bb);
    expect_hit("R8 least recent entry not evicted", 8'd1, 20'h00102, 20'h00202);
    fill(8'd1, 20'h00103, 20'h003cc, 2'b11);
    expect_hit("R10 overwrite gives new frame", 8'd1, 20'h00103, 20'h003cc);
    for (int i = 2; i < N; i++)
      if (i != 3 && i != 5)
        expect_hit("R10 no other entry evicted", 8'd1, 20'h00100 + 20'(i), 20'h00200 + 20'(i));
    expect_hit("R10 entry 0 kept", 8'd1, 20'h00100, 20'h00200);
    expect_hit("R10 filled entries kept", 8'd1, 20'h001aa, 20'h002aa);
    do_flush(1, 8'd0);
    expect_miss("R6 full table flushed", 8'd1, 20'h00100);
    expect_miss("R6 full table flushed second", 8'd1, 20'h001bb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic_and_asid();
    t_perm_and_bits();
    t_backpressure();
    t_replacement();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule